// File: doc/BRIEF.md
# Shared-Bus Arbitration Node

This block is one node of a distributed arbiter for an external bus shared by up to four agents. Each agent carries an identical copy of the node and there is no central arbiter. A node drives one request line, selected by its identity input, and it observes all request lines of the system, including its own. Every node holds the same copy of the arbitration state, so all nodes reach the same verdict on the same clock edge. Each node raises its ownership flag only when it is the winner.

A static strap selects the priority scheme. In fixed mode the lowest-numbered agent wins. In rotating mode the agent that released the bus most recently drops to lowest priority. Once granted, an owner keeps the bus for as long as its line stays high. Two things limit this. A programmable hold limit forces an owner that is holding up other agents to withdraw its line for one cycle. A local lock input suppresses that forced withdrawal during back-to-back transfers.

Top module: `shbus_arb_node`

## Requirements
- R1: While reset is low and on the first cycle after it, no node reports ownership. In rotating mode the pointer starts so that agent 0 has the highest priority, followed by 1, 2 and 3.
- R2: Ownership is registered. A node becomes owner on the first clock edge at which its line is visible and it wins. Only the node whose identity equals the winner's index raises `own_bus`.
- R3: With `rot_mode` = 0, when the bus is free (or its owner's line is low), the lowest-indexed high request line wins.
- R4: With `rot_mode` = 1, the search for a winner starts just above the agent that last released the bus and wraps from 3 to 0. The pointer moves on every release, including a release to an idle bus.
- R5: An owner whose line is high keeps the bus, whatever other lines do. When its line is low at an edge, it loses ownership at that edge.
- R6: The owner counts the cycles it holds the bus while another line is high. Take the grant edge as edge 0 and the limit as L ≥ 1, with another line high throughout. The owner's line is forced low for exactly the cycle after edge L+1, and the bus passes to the next winner at edge L+2.
- R7: A limit of 0 disables the forced withdrawal.
- R8: While no other line is high, the owner is never forced to withdraw and its count does not advance.
- R9: While `lock_in` is high, the owner's line follows `req_in` and the count is cleared. After lock drops, counting restarts from zero.
- R10: Across the system, at most one node reports ownership in any cycle. In rotating mode with a non-zero limit, no waiting agent is held out for more than 4·(L+3) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock shared by all nodes |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | 2 | Index of this node (static) |
| rot_mode | input | 1 | Priority strap: 0 fixed, 1 rotating (static) |
| req_in | input | 1 | Local wish to use the bus |
| lock_in | input | 1 | Local lock; suppresses the forced withdrawal |
| tout_limit | input | 8 | Hold limit in cycles; 0 disables |
| req_lines | input | 4 | All request lines as seen on the board, bit i from agent i |
| req_out | output | 1 | This node's request line |
| own_bus | output | 1 | This node owns the bus |

## Verification
The assertions assume three things about the inputs: every node sees the same `req_lines` in the same cycle, identities are unique, and `node_id` and `rot_mode` change only while reset is low. Under these conditions, registered ownership follows from the line vector alone. The bench wires the four nodes' `req_out` straight into one shared vector and gives each node a constant identity. It changes the strap and the hold limit only inside its reset task, with one exception: the limit is lowered to zero while the bus is held, because that input is allowed to change at run time.

// File: rtl/shbus_arb_pkg.sv
// Package: shared helpers for the shared-bus arbitration node.
// Assumes the agent count is at least 2.
package shbus_arb_pkg;

    // Cyclic successor of an agent index within n agents
    function automatic int unsigned slot_after(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/shbus_prio_pick.sv
// Module: picks the first high line, searching cyclically upward from a
// start index. Fixed priority is the special case start = 0.
// Assumes start < N. Purely combinational.
module shbus_prio_pick #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  lines,
    input  logic [IW-1:0] start,
    output logic          win_vld,
    output logic [IW-1:0] win_idx
);

    // Scan from the far end downward so the nearest line from start wins
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= N) idx = idx - N;
            if (lines[idx]) begin
                win_vld = 1'b1;
                win_idx = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/shbus_bus_track.sv
// Module: system-wide arbitration state, kept identically in every node.
// It holds the busy flag, the current owner and the last releaser (the
// rotation pointer), and computes their next values from the shared lines.
// Assumes all nodes sample the same line vector on the same edge.
module shbus_bus_track
    import shbus_arb_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rot_mode,
    input  logic [N-1:0]  lines,
    output logic          busy_q,
    output logic [IW-1:0] owner_q,
    output logic          busy_d,
    output logic [IW-1:0] owner_d
);

    logic [IW-1:0] last_q, last_d;
    logic          release_now, bus_free;
    logic [IW-1:0] ptr_eff, start_idx;
    logic          win_vld;
    logic [IW-1:0] win_idx;

    // Detect the owner's line falling and pick the search origin
    always_comb begin
        release_now = busy_q && !lines[owner_q];
        bus_free    = !busy_q || release_now;
        ptr_eff     = release_now ? owner_q : last_q;
        start_idx   = rot_mode ? IW'(slot_after(int'(ptr_eff), N)) : '0;
    end

    shbus_prio_pick #(.N(N)) u_pick (
        .lines   (lines),
        .start   (start_idx),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    // Next-state values for ownership and the rotation pointer
    always_comb begin
        busy_d  = busy_q;
        owner_d = owner_q;
        last_d  = release_now ? owner_q : last_q;
        if (bus_free) begin
            busy_d = win_vld;
            if (win_vld) owner_d = win_idx;
        end
    end

    // State registers; pointer resets to the top index so agent 0 leads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
            last_q  <= IW'(N - 1);
        end else begin
            busy_q  <= busy_d;
            owner_q <= owner_d;
            last_q  <= last_d;
        end
    end

endmodule

// File: rtl/shbus_tout_guard.sv
// Module: local hold-limit guard. It counts the cycles this node owns the
// bus while another line is high, and raises a one-cycle yield pulse when
// the count reaches the limit. Lock clears the count; a limit of 0 disables.
// Assumes own_now and own_nxt come from the shared tracker.
module shbus_tout_guard #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          own_now,
    input  logic          own_nxt,
    input  logic          others,
    input  logic          lock_in,
    input  logic [TW-1:0] limit,
    output logic          yield_q
);

    logic [TW-1:0] hold_cnt;
    logic          limit_hit;

    // The limit is reached while holding up someone and not locked
    always_comb begin
        limit_hit = own_now && others && !lock_in && (limit != '0)
                    && (hold_cnt >= limit) && !yield_q;
    end

    // Hold counter: cleared outside a continuing tenure or under lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!own_now || !own_nxt || lock_in) begin
            hold_cnt <= '0;
        end else if (others && (hold_cnt != '1)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // One-cycle yield pulse
    always_ff @(posedge clk) begin
        if (!rst_n) yield_q <= 1'b0;
        else        yield_q <= limit_hit;
    end

endmodule

// File: rtl/shbus_arb_node.sv
// Module: one arbitration node of the distributed shared-bus arbiter.
// It drives its own request line (gated by the hold-limit guard) and
// decides its own ownership from the shared line vector.
// Assumes a unique node_id, and a static node_id and rot_mode outside reset.
module shbus_arb_node #(
    parameter int NODES = 4,
    parameter int TW    = 8,
    localparam int IW   = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    node_id,
    input  logic             rot_mode,
    input  logic             req_in,
    input  logic             lock_in,
    input  logic [TW-1:0]    tout_limit,
    input  logic [NODES-1:0] req_lines,
    output logic             req_out,
    output logic             own_bus
);

    logic          busy_q, busy_d;
    logic [IW-1:0] owner_q, owner_d;
    logic          own_nxt, others, yield_q;
    logic [NODES-1:0] self_mask;

    shbus_bus_track #(.N(NODES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot_mode (rot_mode),
        .lines    (req_lines),
        .busy_q   (busy_q),
        .owner_q  (owner_q),
        .busy_d   (busy_d),
        .owner_d  (owner_d)
    );

    // Local view of ownership and of competing requests
    always_comb begin
        self_mask = NODES'(1) << node_id;
        own_bus   = busy_q && (owner_q == node_id);
        own_nxt   = busy_d && (owner_d == node_id);
        others    = |(req_lines & ~self_mask);
        req_out   = req_in && !yield_q;
    end

    shbus_tout_guard #(.TW(TW)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_now (own_bus),
        .own_nxt (own_nxt),
        .others  (others),
        .lock_in (lock_in),
        .limit   (tout_limit),
        .yield_q (yield_q)
    );

endmodule

// File: rtl/shbus_arb_node_chk.sv
// Module: assertion checker for one arbitration node, bound to it below.
// Assumes consistent line vectors and static identity and strap.
module shbus_arb_node_chk #(
    parameter int NODES = 4,
    parameter int TW    = 8,
    localparam int IW   = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IW-1:0]    node_id,
    input logic             rot_mode,
    input logic             req_in,
    input logic             lock_in,
    input logic [TW-1:0]    tout_limit,
    input logic [NODES-1:0] req_lines,
    input logic             req_out,
    input logic             own_bus
);

    logic [NODES-1:0] below_me;
    assign below_me = (NODES'(1) << node_id) - NODES'(1);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !own_bus);

    p_grant_needs_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_bus) |-> $past(req_lines[node_id]));

    p_fixed_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(own_bus) && !rot_mode) |-> (($past(req_lines) & below_me) == '0));

    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_bus && req_lines[node_id]) |=> own_bus);

    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_bus && !req_lines[node_id]) |=> !own_bus);

    p_yield_hands_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_bus && req_in && !req_out && req_lines == {NODES{1'b0}} | ~(NODES'(1) << node_id) & req_lines)
        |=> !own_bus);

    p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in && tout_limit == '0 && $past(tout_limit) == '0) |-> req_out);

    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in && lock_in && $past(lock_in)) |-> req_out);

endmodule

bind shbus_arb_node shbus_arb_node_chk #(.NODES(NODES), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_id    (node_id),
    .rot_mode   (rot_mode),
    .req_in     (req_in),
    .lock_in    (lock_in),
    .tout_limit (tout_limit),
    .req_lines  (req_lines),
    .req_out    (req_out),
    .own_bus    (own_bus)
);

// File: tb/shbus_arb_node_bench.sv
`timescale 1ns/1ps
// Bench: four nodes on one shared line vector; scoreboard of expected
// ownership and line vectors, plus per-cycle exclusivity and starvation checks.
module shbus_arb_node_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rot_mode = 1'b0;
    logic [7:0] lim = 8'd0;
    logic [3:0] req_in = 4'b0;
    logic [3:0] lock_in = 4'b0;
    logic [3:0] req_out;
    logic [3:0] own;
    logic       starve_en = 1'b0;
    int         errors = 0;
    int         checks = 0;
    int         wait_cnt [4];

    typedef struct {
        logic [3:0] own;
        logic [3:0] lines;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_node
        shbus_arb_node u_shbus_arb_node (
            .clk        (clk),
            .rst_n      (rst_n),
            .node_id    (2'(g)),
            .rot_mode   (rot_mode),
            .req_in     (req_in[g]),
            .lock_in    (lock_in[g]),
            .tout_limit (lim),
            .req_lines  (req_out),
            .req_out    (req_out[g]),
            .own_bus    (own[g])
        );
    end

    // Driver: apply inputs at the falling edge and queue the expected result
    task automatic step(input logic [3:0] r, input logic [3:0] lk,
                        input logic [3:0] e_own, input logic [3:0] e_lines,
                        input string tag);
        @(negedge clk);
        req_in  = r;
        lock_in = lk;
        sb_q.push_back('{e_own, e_lines, tag});
    endtask

    task automatic do_reset(input logic rot, input logic [7:0] l);
        @(negedge clk);
        rst_n = 1'b0; req_in = '0; lock_in = '0; rot_mode = rot; lim = l;
        repeat (2) @(negedge clk);
        checks++;
        if (own !== 4'b0) begin
            errors++;
            $display("FAIL R1 in reset own=%b expected=0000", own);
        end
        rst_n = 1'b1;
    endtask

    // Monitor: compare after each rising edge against the scoreboard
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (own !== it.own || req_out !== it.lines) begin
                errors++;
                $display("FAIL %s own=%b lines=%b expected own=%b lines=%b",
                         it.tag, own, req_out, it.own, it.lines);
            end
        end
    end

    // R10: exclusivity every cycle; starvation bound in the stress phase
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            checks++;
            if ($countones(own) > 1) begin
                errors++;
                $display("FAIL R10 owners=%b expected at most one", own);
            end
            for (int i = 0; i < 4; i++) begin
                if (starve_en && req_out[i] && !own[i]) wait_cnt[i]++;
                else wait_cnt[i] = 0;
                if (wait_cnt[i] > 4 * (int'(lim) + 3)) begin
                    errors++;
                    $display("FAIL R10 agent %0d waited=%0d expected<=%0d",
                             i, wait_cnt[i], 4 * (int'(lim) + 3));
                    wait_cnt[i] = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1, R2, R3, R5: fixed priority
        do_reset(1'b0, 8'd0);
        step(4'b0000, 4'b0, 4'b0000, 4'b0000, "R1 after reset");
        step(4'b1010, 4'b0, 4'b0010, 4'b1010, "R3 lowest of 1,3");
        step(4'b1011, 4'b0, 4'b0010, 4'b1011, "R5 no preemption");
        step(4'b1001, 4'b0, 4'b0001, 4'b1001, "R3 release to 0");
        step(4'b1000, 4'b0, 4'b1000, 4'b1000, "R2 grant to 3");
        step(4'b0000, 4'b0, 4'b0000, 4'b0000, "R5 drop to idle");
        // R4: rotating priority
        do_reset(1'b1, 8'd0);
        step(4'b1111, 4'b0, 4'b0001, 4'b1111, "R1 rotating start at 0");
        step(4'b1110, 4'b0, 4'b0010, 4'b1110, "R4 after 0 comes 1");
        step(4'b1101, 4'b0, 4'b0100, 4'b1101, "R4 after 1 comes 2");
        step(4'b1011, 4'b0, 4'b1000, 4'b1011, "R4 after 2 comes 3");
        step(4'b0111, 4'b0, 4'b0001, 4'b0111, "R4 wrap to 0");
        step(4'b0000, 4'b0, 4'b0000, 4'b0000, "R4 idle release");
        step(4'b1001, 4'b0, 4'b1000, 4'b1001, "R4 pointer moved on idle release");
        step(4'b0000, 4'b0, 4'b0000, 4'b0000, "R4 idle");
        // R6, R9: hold limit 3, fixed mode
        do_reset(1'b0, 8'd3);
        step(4'b0011, 4'b0, 4'b0001, 4'b0011, "R6 grant edge");
        for (int i = 0; i < 3; i++) step(4'b0011, 4'b0, 4'b0001, 4'b0011, "R6 counting");
        step(4'b0011, 4'b0, 4'b0001, 4'b0010, "R6 forced withdrawal");
        step(4'b0011, 4'b0, 4'b0010, 4'b0011, "R6 handover");
        for (int i = 0; i < 8; i++) step(4'b0011, 4'b0010, 4'b0010, 4'b0011, "R9 lock holds");
        for (int i = 0; i < 3; i++) step(4'b0011, 4'b0, 4'b0010, 4'b0011, "R9 count restarts");
        step(4'b0011, 4'b0, 4'b0010, 4'b0001, "R9 withdrawal after lock");
        step(4'b0011, 4'b0, 4'b0001, 4'b0011, "R6 handover back");
        step(4'b0000, 4'b0, 4'b0000, 4'b0000, "R5 idle");
        // R8: sole requester is never forced out
        for (int i = 0; i < 8; i++) step(4'b0001, 4'b0, 4'b0001, 4'b0001, "R8 alone");
        // R7: limit 0 disables the withdrawal
        lim = 8'd0;
        for (int i = 0; i < 8; i++) step(4'b0011, 4'b0, 4'b0001, 4'b0011, "R7 limit zero");
        step(4'b0000, 4'b0, 4'b0000, 4'b0000, "R7 idle");
        // R10: rotating stress with limit 2
        do_reset(1'b1, 8'd2);
        @(negedge clk);
        starve_en = 1'b1;
        req_in = 4'b1111;
        repeat (200) @(negedge clk);
        starve_en = 1'b0;
        req_in = 4'b0000;
        repeat (4) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule